// File: doc/BRIEF.md
# Segmented Posted-Write Data Buffer

This block holds posted memory-write data for one crossing direction of a bus bridge. Data is kept in a shared pool of 128-byte subsections. With a 64-bit data path each subsection holds 16 words. A write claims subsections one at a time as its data arrives. It can hold between one and eight of them, and a write longer than 1024 bytes is cut into several queue entries. Each entry records the write's start address, its byte count and the ordered indices of the subsections it holds. The queue keeps at most eight entries.

The ingress side takes one word per handshake. `in_start` and `in_addr` go with the first word of a write, and `in_last` marks its final word. The egress side drains whole entries in arrival order. It presents each word together with the entry's address and byte count, and raises a last flag on the final word of every entry. A subsection goes back to the free pool on the same handshake that drains its final word, so a stalled ingress can resume before the write that held that subsection has finished leaving.

Top module: `seg_post_wbuf`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Egress words come out in the order ingress accepted them, with the same data. `out_last` is 1 exactly on the final word of each entry.
- R3: While `out_valid` is 1, `out_addr` gives the entry's start address and `out_bytes` gives 8 times the number of words in the entry.
- R4: A write of more than 128 words is split into entries of 128 words, and the remainder forms the final entry. A continuation entry starts 1024 bytes above the entry before it. `out_last` is raised on the 128th word of each full entry.
- R5: An entry is offered at egress only after its final word has been accepted, or after its 128th word when the write is split. A partly received write leaves `out_valid` at 0.
- R6: Eight entries are the limit. When eight complete entries are waiting, the first word of a new entry is refused (`in_ready` is 0) until egress finishes an entry.
- R7: A word that begins a subsection (the entry's word count is a multiple of 16) is refused while no subsection is free. Words that fall inside an already claimed subsection are accepted regardless of the pool.
- R8: A subsection becomes free on the cycle after egress accepts its 16th word, or after the entry's final word. Ingress stalled for space resumes on that cycle, while the rest of the entry is still queued.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_last` and `out_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress word present |
| in_ready | output | 1 | Ingress word accepted this cycle if valid |
| in_start | input | 1 | First word of a write; `in_addr` is sampled |
| in_addr | input | 64 | Start byte address of the write |
| in_data | input | 64 | Ingress data word |
| in_last | input | 1 | Final word of the write |
| out_valid | output | 1 | Egress word present |
| out_ready | input | 1 | Egress consumer accepts the word |
| out_data | output | 64 | Egress data word |
| out_last | output | 1 | Final word of the current entry |
| out_addr | output | 64 | Start address of the current entry |
| out_bytes | output | 11 | Byte count of the current entry |

## Verification
The bench targets the subsection boundaries. One case fills the pool completely while egress is stalled and then releases exactly one subsection. A design that frees space only when a whole write completes would keep `in_ready` low there, and one that frees a subsection one word early would overwrite data that has not yet been drained. The split case sends a 300-word write. An off-by-one in the split would put `out_last` on the wrong word or give the continuation entry the wrong address. Further cases stall with eight entries queued, and begin a new write when only one subsection remains free. A design that checks queue room on every word, or checks pool room inside a subsection, would stall where the reference model accepts, and one that skips these checks would corrupt data or the queue.

// File: rtl/seg_post_wbuf.sv
module seg_post_wbuf #(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 64,
  parameter int SEG_BYTES = 128,
  parameter int MAX_SEGS  = 8,
  parameter int NUM_SEGS  = 16,
  parameter int QDEPTH    = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic                                     in_start,
  input  logic [ADDR_W-1:0]                        in_addr,
  input  logic [DATA_W-1:0]                        in_data,
  input  logic                                     in_last,
  output logic                                     out_valid,
  input  logic                                     out_ready,
  output logic [DATA_W-1:0]                        out_data,
  output logic                                     out_last,
  output logic [ADDR_W-1:0]                        out_addr,
  output logic [$clog2(SEG_BYTES*MAX_SEGS):0]      out_bytes
);
  localparam int SEG_WORDS = SEG_BYTES / (DATA_W / 8);
  localparam int OFF_W     = $clog2(SEG_WORDS);
  localparam int IDX_W     = $clog2(NUM_SEGS);
  localparam int SC_W      = $clog2(MAX_SEGS);
  localparam int QP_W      = $clog2(QDEPTH);
  localparam int MAX_WORDS = SEG_WORDS * MAX_SEGS;
  localparam int WC_W      = $clog2(MAX_WORDS) + 1;
  localparam int BYTE_W    = $clog2(SEG_BYTES * MAX_SEGS) + 1;
  localparam int SHIFT     = $clog2(DATA_W / 8);
  localparam int ENT_BYTES = SEG_BYTES * MAX_SEGS;

  logic [DATA_W-1:0] mem     [NUM_SEGS*SEG_WORDS];
  logic [ADDR_W-1:0] q_addr  [QDEPTH];
  logic [WC_W-1:0]   q_words [QDEPTH];
  logic [IDX_W-1:0]  q_seg   [QDEPTH][MAX_SEGS];

  logic [NUM_SEGS-1:0] free_mask;
  logic [QP_W-1:0]     wp, rp;
  logic [QP_W:0]       cnt;

  logic [WC_W-1:0]   ent_words;
  logic [ADDR_W-1:0] nxt_addr;
  logic [IDX_W-1:0]  cur_seg;

  logic [SC_W-1:0]   rd_seg;
  logic [OFF_W-1:0]  rd_off;
  logic [WC_W-1:0]   rd_words;

  logic [IDX_W-1:0]  alloc_idx;
  logic              any_free;

  always_comb begin
    alloc_idx = '0;
    for (int i = NUM_SEGS - 1; i >= 0; i--)
      if (free_mask[i]) alloc_idx = IDX_W'(i);
  end
  assign any_free = |free_mask;

  logic              need_seg, new_ent, in_fire, in_commit;
  logic [IDX_W-1:0]  wseg;
  logic [ADDR_W-1:0] ent_addr;
  logic [SC_W-1:0]   seg_no;

  assign need_seg  = ent_words[OFF_W-1:0] == '0;
  assign new_ent   = ent_words == '0;
  assign in_ready  = (!need_seg || any_free) && (!new_ent || cnt < (QP_W+1)'(QDEPTH));
  assign in_fire   = in_valid && in_ready;
  assign in_commit = in_fire && (in_last || ent_words == WC_W'(MAX_WORDS - 1));
  assign wseg      = need_seg ? alloc_idx : cur_seg;
  assign ent_addr  = in_start ? in_addr : nxt_addr;
  assign seg_no    = ent_words[OFF_W+SC_W-1:OFF_W];

  logic              out_fire, pop, rel_en;
  logic [IDX_W-1:0]  rseg;

  assign rseg      = q_seg[rp][rd_seg];
  assign out_valid = cnt != '0;
  assign out_data  = mem[{rseg, rd_off}];
  assign out_last  = (rd_words + WC_W'(1)) == q_words[rp];
  assign out_addr  = q_addr[rp];
  assign out_bytes = BYTE_W'(q_words[rp]) << SHIFT;
  assign out_fire  = out_valid && out_ready;
  assign pop       = out_fire && out_last;
  assign rel_en    = out_fire && (rd_off == '1 || out_last);

  always_ff @(posedge clk)
    if (in_fire) mem[{wseg, ent_words[OFF_W-1:0]}] <= in_data;

  always_ff @(posedge clk)
    if (in_fire) begin
      if (new_ent)   q_addr[wp] <= ent_addr;
      if (need_seg)  q_seg[wp][seg_no] <= alloc_idx;
      if (in_commit) q_words[wp] <= ent_words + WC_W'(1);
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_mask <= '1;
    end else begin
      if (in_fire && need_seg) free_mask[alloc_idx] <= 1'b0;
      if (rel_en)              free_mask[rseg]      <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_words <= '0;
      nxt_addr  <= '0;
      cur_seg   <= '0;
      wp        <= '0;
    end else if (in_fire) begin
      if (new_ent)  nxt_addr <= ent_addr + ADDR_W'(ENT_BYTES);
      if (need_seg) cur_seg  <= alloc_idx;
      ent_words <= in_commit ? '0 : ent_words + WC_W'(1);
      if (in_commit) wp <= wp + QP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp       <= '0;
      rd_seg   <= '0;
      rd_off   <= '0;
      rd_words <= '0;
    end else if (out_fire) begin
      if (out_last) begin
        rp       <= rp + QP_W'(1);
        rd_seg   <= '0;
        rd_off   <= '0;
        rd_words <= '0;
      end else begin
        rd_words <= rd_words + WC_W'(1);
        rd_off   <= rd_off + OFF_W'(1);
        if (rd_off == '1) rd_seg <= rd_seg + SC_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + {{QP_W{1'b0}}, in_commit} - {{QP_W{1'b0}}, pop};
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && in_ready);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_addr));

  // R6
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (QP_W+1)'(QDEPTH));

  // R4
  entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_words < WC_W'(MAX_WORDS));

  // R8
  release_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> !free_mask[rseg]);

  // R3
  out_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bytes != '0 && out_bytes <= BYTE_W'(ENT_BYTES));
endmodule

// File: tb/tb_seg_post_wbuf.sv
module tb_seg_post_wbuf;
  localparam int SEGW = 16;
  localparam int MAXW = 128;
  localparam int NSEG = 16;
  localparam int QD   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [63:0] in_addr = '0, in_data = '0;
  logic        in_ready, out_valid, out_last;
  logic [63:0] out_data, out_addr;
  logic [10:0] out_bytes;

  always #2 clk = ~clk;

  seg_post_wbuf dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_start(in_start),
    .in_addr(in_addr), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_addr(out_addr), .out_bytes(out_bytes)
  );

  logic [63:0] s_data[$], s_addr[$];
  bit          s_start[$], s_last[$];

  logic [63:0] m_addr[$], m_dat[$];
  int          m_len[$];
  int          cur_len = 0, hpos = 0, free_cnt = NSEG;
  logic [63:0] cur_addr = '0, nxt_addr = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0, ordy = 0;
  bit gap = 0, done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push_txn(logic [63:0] addr, int n, int id);
    for (int i = 0; i < n; i++) begin
      s_data.push_back({id[31:0], i[31:0]} ^ 64'h5a5a_0000_a5a5_0000);
      s_addr.push_back(addr);
      s_start.push_back(i == 0);
      s_last.push_back(i == n - 1);
    end
  endtask

  task automatic step();
    bit e_rdy, e_val, inf, outf, st, ls;
    logic [63:0] d, a;
    @(negedge clk);
    in_valid  = s_data.size() > 0 && !(gap && cyc % 3 == 1);
    in_data   = s_data.size() > 0 ? s_data[0] : '0;
    in_addr   = s_data.size() > 0 ? s_addr[0] : '0;
    in_start  = s_data.size() > 0 ? s_start[0] : 1'b0;
    in_last   = s_data.size() > 0 ? s_last[0] : 1'b0;
    out_ready = ordy == 1 || (ordy == 2 && cyc % 2 == 0);
    #1;
    e_rdy = (cur_len % SEGW != 0 || free_cnt > 0) && (cur_len != 0 || m_len.size() < QD);
    chk("R7 in_ready", 64'(in_ready), 64'(e_rdy));
    e_val = m_len.size() > 0;
    chk("R5 out_valid", 64'(out_valid), 64'(e_val));
    if (e_val) begin
      // R9: with out_ready low the model holds its head, so the held values are compared here
      chk("R2 out_data", out_data, m_dat[0]);
      chk("R2 out_last", 64'(out_last), 64'(hpos + 1 == m_len[0]));
      chk("R3 out_addr", out_addr, m_addr[0]);
      chk("R3 out_bytes", 64'(out_bytes), 64'(m_len[0] * 8));
    end
    inf  = in_valid && in_ready;
    outf = out_valid && out_ready && e_val;
    d = in_data; a = in_addr; st = in_start; ls = in_last;
    if (outf) begin
      void'(m_dat.pop_front());
      hpos++;
      if (hpos % SEGW == 0 || hpos == m_len[0]) free_cnt++;
      if (hpos == m_len[0]) begin
        void'(m_len.pop_front());
        void'(m_addr.pop_front());
        hpos = 0;
      end
    end
    if (inf) begin
      void'(s_data.pop_front()); void'(s_addr.pop_front());
      void'(s_start.pop_front()); void'(s_last.pop_front());
      if (cur_len % SEGW == 0) free_cnt--;
      if (cur_len == 0) begin
        cur_addr = st ? a : nxt_addr;
        nxt_addr = cur_addr + 64'd1024;
      end
      m_dat.push_back(d);
      cur_len++;
      if (ls || cur_len == MAXW) begin
        m_addr.push_back(cur_addr);
        m_len.push_back(cur_len);
        cur_len = 0;
      end
    end
    cyc++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drain(int maxc);
    int k = 0;
    while ((s_data.size() > 0 || m_len.size() > 0 || cur_len != 0) && k < maxc) begin
      step();
      k++;
    end
    chk("R2 drain completes", 64'(k < maxc), 64'd1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk("R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);

    // R5: partial write stays invisible
    ordy = 1; gap = 0;
    push_txn(64'h0000_0000_0000_4000, 60, 1);
    run(30);
    chk("R5 partial write hidden", 64'(out_valid), 64'd0);
    drain(400);

    // R2, R3, R9: mixed lengths with gaps and back-pressure
    ordy = 2; gap = 1;
    push_txn(64'h0000_0001_0000_0000, 1, 2);
    push_txn(64'h0000_0000_0000_0100, 3, 3);
    push_txn(64'h0000_0000_0000_0200, 16, 4);
    push_txn(64'h0000_0000_0000_0300, 17, 5);
    push_txn(64'h8000_0000_0000_0000, 40, 6);
    drain(2000);

    // R4: long write split into 128, 128, 44
    ordy = 1; gap = 0;
    push_txn(64'h0000_1000_0000_0000, 300, 7);
    drain(2000);

    // R6: eight entries waiting blocks a ninth
    ordy = 0;
    for (int t = 0; t < 9; t++) push_txn(64'h2000 + 64'(t * 64), 1, 10 + t);
    run(40);
    chk("R6 ninth write refused", 64'(in_ready), 64'd0);
    chk("R6 ninth write still pending", 64'(s_data.size()), 64'd1);
    ordy = 1;
    drain(400);

    // R7, R8: pool exhausted, then one subsection recycled
    ordy = 0;
    push_txn(64'h0000_0000_0001_0000, 128, 20);
    push_txn(64'h0000_0000_0002_0000, 128, 21);
    push_txn(64'h0000_0000_0003_0000, 20, 22);
    run(300);
    chk("R7 stall with empty pool", 64'(s_data.size()), 64'd20);
    ordy = 1;
    run(16);
    ordy = 0;
    run(3);
    chk("R8 resume after one subsection", 64'(s_data.size() < 20), 64'd1);
    ordy = 1;
    drain(2000);

    // R7: words inside a claimed subsection proceed, a new one waits
    ordy = 0;
    push_txn(64'h0000_0000_0004_0000, 128, 30);
    push_txn(64'h0000_0000_0005_0000, 100, 31);
    push_txn(64'h0000_0000_0006_0000, 40, 32);
    run(320);
    chk("R7 last free subsection filled", 64'(s_data.size()), 64'd24);
    ordy = 2;
    drain(3000);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule